// File: doc/BRIEF.md
# Fractional-N Feedback Divider Controller

This block sits in the feedback path of a fractional-N synthesizer. It runs on the prescaled RF clock. It emits one single-clock pulse toward the phase detector for every divide cycle. The length of each cycle is an integer that changes from cycle to cycle, and the long-run mean of those integers equals the programmed integer word plus the programmed fraction divided by 2^25. A third-order noise-shaping modulator, built from three cascaded 25-bit accumulators, produces a small signed offset. That offset is added to the integer word once per divide cycle and latched into a down-counter.

Configuration arrives on a parallel port with a write strobe. A write is parked in a pending stage. It becomes active only at the next divide-cycle boundary, so a count that is already running is never cut short. An integer word below 23 is raised to 23, and a flag output records that the last write was out of range.

Top module: `fracn_fbdiv`

## Requirements
- R1: While reset is asserted, `div_pulse` and `int_clamped` are 0. After reset the block runs with integer 23 and fraction 0, so pulses are exactly 23 clocks apart.
- R2: `div_pulse` is high for exactly one clock per divide cycle. The spacing between consecutive pulses equals the ratio latched at the earlier pulse.
- R3: With fraction 0, every interval is exactly the integer word. This also holds in the first cycle after a nonzero fraction is replaced by 0.
- R4: Over M consecutive divide cycles, the total clock count is within ±4 of M × (INT + FRAC/2^25).
- R5: The modulator offset lies in −3..+4. Every interval therefore lies in INT−3..INT+4.
- R6: A write lets the interval already in progress finish with the old setting. The interval that begins at the next pulse uses the new setting.
- R7: An integer word below 23 is applied as 23, and `int_clamped` goes to 1.
- R8: `int_clamped` updates one clock after each write. A write with an integer word of 23 or more clears it.
- R9: The largest integer word, 4095, with fraction 0, gives 4095-clock intervals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaled RF clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration words |
| cfg_int | input | 12 | Integer part of the division ratio |
| cfg_frac | input | 25 | Fractional numerator over 2^25 |
| div_pulse | output | 1 | One-clock pulse per divide cycle |
| int_clamped | output | 1 | Last written integer word was below 23 |

## Verification
The bench programs a write in the middle of a running count. A design that applied the new setting immediately would produce a truncated or stretched interval. It switches from a nonzero fraction back to zero. A modulator that kept its residual accumulator state would then keep dithering where a pure integer count is required. Long fractional runs measure the mean ratio at fractions of one half, about one third, and the maximum. Carry or sign mistakes in the offset combiner show up there as a drifting mean or as intervals outside INT−3..INT+4. Integer words of 0 and 10 exercise the clamp, and 4095 exercises the counter's full width.

// File: rtl/fnd_pkg.sv
package fnd_pkg;
  localparam int unsigned FND_INT_W  = 12;
  localparam int unsigned FND_FRAC_W = 25;
  localparam int unsigned FND_INT_MIN = 23;
  localparam int unsigned FND_OFS_W  = 4;
  typedef logic signed [FND_OFS_W-1:0] fnd_ofs_t;
endpackage

// File: rtl/fnd_rst_sync.sv
module fnd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ni = sync_q[STAGES-1];
endmodule

// File: rtl/fnd_mash.sv
module fnd_mash
  import fnd_pkg::*;
#(
  parameter int unsigned FRAC_W = FND_FRAC_W
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              step,
  input  logic [FRAC_W-1:0] frac,
  output fnd_ofs_t          ofs
);
  localparam int unsigned ORDER = 3;

  logic [FRAC_W-1:0] acc_q [ORDER];
  logic [FRAC_W-1:0] acc_n [ORDER];
  logic [ORDER-1:0]  cy;
  logic              c2d_q, c3d_q, c3dd_q;
  logic              frac_zero;

  assign frac_zero = (frac == '0);

  for (genvar g = 0; g < ORDER; g++) begin : g_stage
    logic [FRAC_W:0] sum;
    if (g == 0) begin : g_first
      assign sum = {1'b0, acc_q[g]} + {1'b0, frac};
    end else begin : g_next
      assign sum = {1'b0, acc_q[g]} + {1'b0, acc_n[g-1]};
    end
    assign acc_n[g] = sum[FRAC_W-1:0];
    assign cy[g]    = sum[FRAC_W];

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)     acc_q[g] <= '0;
      else if (step)   acc_q[g] <= frac_zero ? '0 : acc_n[g];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      c2d_q  <= 1'b0;
      c3d_q  <= 1'b0;
      c3dd_q <= 1'b0;
    end else if (step) begin
      c2d_q  <= frac_zero ? 1'b0 : cy[1];
      c3d_q  <= frac_zero ? 1'b0 : cy[2];
      c3dd_q <= frac_zero ? 1'b0 : c3d_q;
    end
  end

  // Stage 1 carry, plus first difference of stage 2, plus second difference of stage 3.
  always_comb begin
    if (frac_zero) begin
      ofs = '0;
    end else begin
      ofs = fnd_ofs_t'({3'b0, cy[0]})
          + fnd_ofs_t'({3'b0, cy[1]}) - fnd_ofs_t'({3'b0, c2d_q})
          + fnd_ofs_t'({3'b0, cy[2]}) - fnd_ofs_t'({2'b0, c3d_q, 1'b0})
          + fnd_ofs_t'({3'b0, c3dd_q});
    end
  end
endmodule

// File: rtl/fnd_divcnt.sv
module fnd_divcnt #(
  parameter int unsigned RATIO_W = 13,
  parameter int unsigned RST_CNT = 22
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] load_val,
  output logic               wrap
);
  logic [RATIO_W-1:0] cnt_q, cnt_n;

  assign wrap = (cnt_q == '0);

  always_comb begin
    if (wrap) cnt_n = load_val - RATIO_W'(1);
    else      cnt_n = cnt_q - RATIO_W'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= RATIO_W'(RST_CNT);
    else         cnt_q <= cnt_n;
  end

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    wrap |=> !wrap);
endmodule

// File: rtl/fracn_fbdiv.sv
module fracn_fbdiv
  import fnd_pkg::*;
#(
  parameter int unsigned INT_W   = FND_INT_W,
  parameter int unsigned FRAC_W  = FND_FRAC_W,
  parameter int unsigned INT_MIN = FND_INT_MIN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [INT_W-1:0]  cfg_int,
  input  logic [FRAC_W-1:0] cfg_frac,
  output logic              div_pulse,
  output logic              int_clamped
);
  localparam int unsigned RATIO_W = INT_W + 1;
  localparam int unsigned SUM_W   = INT_W + 2;

  logic              rst_ni;
  logic [INT_W-1:0]  act_int_q, act_int_n, pend_int_q, pend_int_n, eff_int, wr_int;
  logic [FRAC_W-1:0] act_frac_q, act_frac_n, pend_frac_q, pend_frac_n, eff_frac;
  logic              pend_v_q, pend_v_n, clamp_q, clamp_n, wr_low;
  logic              wrap;
  fnd_ofs_t          ofs;
  logic signed [SUM_W-1:0] ratio_s;
  logic [RATIO_W-1:0]      ratio;

  fnd_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_ni(rst_ni));

  assign eff_int  = pend_v_q ? pend_int_q  : act_int_q;
  assign eff_frac = pend_v_q ? pend_frac_q : act_frac_q;
  assign wr_low   = (cfg_int < INT_W'(INT_MIN));
  assign wr_int   = wr_low ? INT_W'(INT_MIN) : cfg_int;

  fnd_mash #(.FRAC_W(FRAC_W)) u_mash (
    .clk(clk), .rst_ni(rst_ni), .step(wrap), .frac(eff_frac), .ofs(ofs)
  );

  assign ratio_s = $signed({2'b00, eff_int}) + SUM_W'(ofs);
  assign ratio   = ratio_s[RATIO_W-1:0];

  fnd_divcnt #(.RATIO_W(RATIO_W), .RST_CNT(INT_MIN - 1)) u_cnt (
    .clk(clk), .rst_ni(rst_ni), .load_val(ratio), .wrap(wrap)
  );

  always_comb begin
    act_int_n   = act_int_q;
    act_frac_n  = act_frac_q;
    pend_int_n  = pend_int_q;
    pend_frac_n = pend_frac_q;
    pend_v_n    = pend_v_q;
    clamp_n     = clamp_q;
    if (wrap) begin
      act_int_n  = eff_int;
      act_frac_n = eff_frac;
      pend_v_n   = 1'b0;
    end
    if (cfg_we) begin
      pend_int_n  = wr_int;
      pend_frac_n = cfg_frac;
      pend_v_n    = 1'b1;
      clamp_n     = wr_low;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      act_int_q   <= INT_W'(INT_MIN);
      act_frac_q  <= '0;
      pend_int_q  <= INT_W'(INT_MIN);
      pend_frac_q <= '0;
      pend_v_q    <= 1'b0;
      clamp_q     <= 1'b0;
    end else begin
      act_int_q   <= act_int_n;
      act_frac_q  <= act_frac_n;
      pend_int_q  <= pend_int_n;
      pend_frac_q <= pend_frac_n;
      pend_v_q    <= pend_v_n;
      clamp_q     <= clamp_n;
    end
  end

  assign div_pulse   = wrap & rst_ni;
  assign int_clamped = clamp_q;

  assert_ofs_range_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    wrap |-> (ofs >= -4'sd3 && ofs <= 4'sd4));
  assert_frac_zero_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (wrap && eff_frac == '0) |-> (ofs == '0));
  assert_int_floor_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    act_int_q >= INT_W'(INT_MIN) && pend_int_q >= INT_W'(INT_MIN));
  assert_hold_cfg_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    !wrap |=> ($stable(act_int_q) && $stable(act_frac_q)));
  assert_flag_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    cfg_we |=> (int_clamped == ($past(cfg_int) < INT_W'(INT_MIN))));
endmodule

// File: tb/fracn_fbdiv_test.sv
module fracn_fbdiv_test;
  typedef struct {
    int    lo;
    int    hi;
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [11:0] cfg_int = '0;
  logic [24:0] cfg_frac = '0;
  logic        div_pulse, int_clamped;

  exp_t  q[$];
  int    cyc = 0, last_cyc = 0;
  bit    have_last = 0, done = 0;
  int    n_chk = 0, n_fail = 0;
  int    cur_lo = 23, cur_hi = 23;

  always #2 clk = ~clk;

  fracn_fbdiv uut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_int(cfg_int),
                   .cfg_frac(cfg_frac), .div_pulse(div_pulse), .int_clamped(int_clamped));

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: compare each completed interval with the front of the scoreboard.
  always @(negedge clk) begin
    if (rst_n && div_pulse) begin
      if (have_last && q.size() > 0) begin
        exp_t e;
        int   d;
        e = q.pop_front();
        d = cyc - last_cyc;
        check(d >= e.lo && d <= e.hi, e.tag, d, e.lo);
      end
      last_cyc  = cyc;
      have_last = 1;
    end
  end

  task automatic push(input int lo, input int hi, input string tag);
    exp_t e;
    e.lo = lo; e.hi = hi; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (!div_pulse);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
  endtask

  // Driver: write mid-count, expect the in-flight interval unchanged (R6), then n new ones.
  task automatic apply(input int iv, input int fv, input int n, input int lo, input int hi,
                       input string tag, input bit exp_flag, input string ftag);
    wait_pulse();
    #1 push(cur_lo, cur_hi, "R6");
    repeat (3) @(negedge clk);
    cfg_int = 12'(iv); cfg_frac = 25'(fv); cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    check(int_clamped == exp_flag, ftag, int_clamped, exp_flag);
    wait_pulse();
    #1;
    for (int k = 0; k < n; k++) push(lo, hi, tag);
    cur_lo = lo; cur_hi = hi;
    drain();
  endtask

  task automatic average(input int iv, input int fv, input int m);
    int  t0;
    real ex, diff;
    wait_pulse();
    t0 = cyc;
    for (int k = 0; k < m; k++) wait_pulse();
    ex   = real'(m) * (real'(iv) + real'(fv) / 33554432.0);
    diff = real'(cyc - t0) - ex;
    if (diff < 0.0) diff = -diff;
    check(diff <= 4.0, "R4", cyc - t0, int'(ex));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(div_pulse == 1'b0, "R1 pulse in reset", div_pulse, 0);
    check(int_clamped == 1'b0, "R1 flag in reset", int_clamped, 0);
    rst_n = 1'b1;
    wait_pulse();
    #1 for (int k = 0; k < 4; k++) push(23, 23, "R1");
    drain();
    apply(100, 0, 4, 100, 100, "R2", 1'b0, "R8");
    apply(10, 0, 3, 23, 23, "R7", 1'b1, "R7");
    apply(0, 0, 2, 23, 23, "R7", 1'b1, "R7");
    apply(23, 25'h1000000, 40, 20, 27, "R5", 1'b0, "R8");
    average(23, 25'h1000000, 200);
    apply(500, 0, 3, 500, 500, "R3", 1'b0, "R8");
    apply(5, 25'h0AAAAAA, 30, 20, 27, "R5", 1'b1, "R7");
    average(23, 25'h0AAAAAA, 300);
    apply(1000, 25'h1FFFFFF, 20, 997, 1004, "R5", 1'b0, "R8");
    average(1000, 25'h1FFFFFF, 50);
    apply(4095, 0, 2, 4095, 4095, "R9", 1'b0, "R8");
    apply(300, 0, 2, 300, 300, "R3", 1'b0, "R8");
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule